// File: doc/BRIEF.md
# SPI Slave Register Bank

This block is the device side of a four-wire serial link that gives a host access to a bank of 64 configuration registers, each 24 bits wide. Every transaction is one 32-bit frame, sent most significant bit first. Bit 31 selects the operation. Bits 30:25 carry the register number. Bits 23:0 carry the write value. Bit 24 has no meaning and is ignored.

The chip-select input is active high. The link runs with the clock idling high, and the device samples on the first (falling) edge of each bit. All serial pins pass through a synchronizer into the local system clock. The serial clock must therefore run well below the system clock, with each serial clock phase lasting at least `SYNC_STAGES + 2` system clocks.

A write commits when chip-select drops after exactly 32 bits. A read is split over two frames. The frame that carries the read request captures the register contents when it ends. The next frame, whatever it carries, shifts those contents back to the host. This lets a run of reads overlap: each frame returns the data that the frame before it asked for.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset every register except the revision register holds 0, the first frame returns an all-zero word, and the serial output is low while chip-select is low.
- R2: A 32-bit frame with bit 31 = 1 stores bits 23:0 into the register numbered by bits 30:25 when chip-select falls. Bit 24 of the frame has no effect.
- R3: A 32-bit frame with bit 31 = 0 is a read request. The next frame shifts out, MSB first, the word {bit 31 = 0, bits 30:25 = requested address, bit 24 = 0, bits 23:0 = register value at the end of the request frame}.
- R4: A frame that follows a write, or follows any frame that was not exactly 32 bits, returns an all-zero word.
- R5: A frame with fewer or more than 32 serial clocks changes no register.
- R6: Address 7 always reads the constant `REV_VALUE`, and writes to it have no effect.
- R7: The device samples the serial input on falling serial-clock edges. It changes the serial output only after rising edges. The first returned bit is valid before the first falling edge.
- R8: Reads issued back to back form a pipeline: each read frame returns the data of the previous read request while carrying its own request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs | input | 1 | Chip-select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low while chip-select is low |

## Verification
Checked on every cycle by assertions:
- The bit counter stays within its saturation bound.
- The serial output holds still between rising serial-clock edges.
- A frame result is produced only with chip-select inactive.
- A rejected or write frame clears the return word.
- A register's read value stays put unless a write is issued, and the revision register ignores writes to it.

Shown only by the bench scenarios, which run real frames and compare against a reference model of the bank:
- The two-frame read protocol and its back-to-back pipeline.
- Bit-24 and short/long frame rejection as seen through later reads.
- The contents of all 64 addresses after a full fill.

// File: rtl/spi_regfile_pkg.sv
package spi_regfile_pkg;

   typedef enum logic {
      FRM_READ  = 1'b0,
      FRM_WRITE = 1'b1
   } frm_op_e;

   // opcode bit + address + one spare bit + data
   function automatic int unsigned frame_width(int unsigned aw, int unsigned dw);
      return 1 + aw + 1 + dw;
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] prev
);

   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_pin_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= RST_VAL;
            else if (s == 0) stg[s] <= din;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= stg[STAGES-1];
   end

   assign lvl = stg[STAGES-1];

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
   parameter int unsigned FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_lvl,
   input  logic               cs_rise,
   input  logic               cs_fall,
   input  logic               sclk_rise,
   input  logic               sclk_fall,
   input  logic               mosi,
   input  logic [FRAME_W-1:0] load_word,
   output logic               miso,
   output logic               frame_done,
   output logic               frame_ok,
   output logic [FRAME_W-1:0] frame_word
);

   localparam int unsigned CNT_MAX = FRAME_W + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         frame_word <= '0;
         tx_sh      <= '0;
         frame_done <= 1'b0;
         frame_ok   <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (cs_rise) begin
            cnt        <= '0;
            frame_word <= '0;
            tx_sh      <= load_word;
         end else if (cs_lvl) begin
            if (sclk_fall) begin
               frame_word <= {frame_word[FRAME_W-2:0], mosi};
               if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
            if (sclk_rise) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
         end
         if (cs_fall) begin
            frame_done <= 1'b1;
            frame_ok   <= (cnt == CNT_W'(FRAME_W));
         end
      end
   end

   assign miso = cs_lvl & tx_sh[FRAME_W-1];

   // R5: counter saturates one past a full frame so long frames are detectable
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(CNT_MAX));

   // R7: serial output only moves after a rising serial clock edge
   a_r7_miso_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_lvl && !sclk_rise && !cs_rise) |=> (!cs_lvl || $stable(miso)));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 24,
   parameter int unsigned REV_ADDR = 7,
   parameter logic [DATA_W-1:0] REV_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      for (genvar a = 0; a < DEPTH; a++) begin : g_cell
         if (a == REV_ADDR) begin : g_rev
            assign cells[a] = REV_VALUE;
         end else begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                   q <= '0;
               else if (wr_req && addr == ADDR_W'(a))        q <= wr_data;
            end
            assign cells[a] = q;
         end
      end
   endgenerate

   assign rd_data = cells[addr];

   // R2: a register's value changes only through a write request
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> (addr != $past(addr)) || (rd_data == $past(rd_data)));

   // R6: revision register ignores writes
   a_r6_rev_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && addr == ADDR_W'(REV_ADDR)) |=>
         (addr != $past(addr)) || (rd_data == REV_VALUE));

endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
   import spi_regfile_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 24,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REV_ADDR    = 7,
   parameter logic [DATA_W-1:0] REV_VALUE = 24'h0A5C31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_cs,
   input  logic spi_mosi,
   output logic spi_miso
);

   localparam int unsigned FRAME_W = frame_width(ADDR_W, DATA_W);
   localparam int unsigned OP_BIT  = FRAME_W - 1;
   localparam int unsigned SPARE   = DATA_W;

   generate
      if (REV_ADDR >= (1 << ADDR_W)) begin : g_bad_rev
         $error("spi_regfile_slave: REV_ADDR outside the address range");
      end
   endgenerate

   // pin order: [2] chip-select, [1] serial clock, [0] data in
   logic [2:0] pin_lvl, pin_prev;

   spi_pin_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({spi_cs, spi_sclk, spi_mosi}),
      .lvl   (pin_lvl),
      .prev  (pin_prev)
   );

   logic cs_lvl, cs_rise, cs_fall, sclk_rise, sclk_fall;
   assign cs_lvl    = pin_lvl[2];
   assign cs_rise   =  pin_lvl[2] & ~pin_prev[2];
   assign cs_fall   = ~pin_lvl[2] &  pin_prev[2];
   assign sclk_rise =  pin_lvl[1] & ~pin_prev[1];
   assign sclk_fall = ~pin_lvl[1] &  pin_prev[1];

   logic               frame_done, frame_ok;
   logic [FRAME_W-1:0] frame_word, ret_word;

   spi_frame_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_lvl     (cs_lvl),
      .cs_rise    (cs_rise),
      .cs_fall    (cs_fall),
      .sclk_rise  (sclk_rise),
      .sclk_fall  (sclk_fall),
      .mosi       (pin_lvl[0]),
      .load_word  (ret_word),
      .miso       (spi_miso),
      .frame_done (frame_done),
      .frame_ok   (frame_ok),
      .frame_word (frame_word)
   );

   frm_op_e           op;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic              wr_req;

   assign op      = frm_op_e'(frame_word[OP_BIT]);
   assign addr    = frame_word[OP_BIT-1 -: ADDR_W];
   assign wr_data = frame_word[DATA_W-1:0];
   assign wr_req  = frame_done & frame_ok & (op == FRM_WRITE);

   logic unused_bits;
   assign unused_bits = ^{pin_prev[0], frame_word[SPARE]};

   spi_reg_bank #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .REV_ADDR  (REV_ADDR),
      .REV_VALUE (REV_VALUE)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (wr_req),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   // word returned by the next frame, captured as the current frame ends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_word <= '0;
      end else if (frame_done) begin
         if (frame_ok && op == FRM_READ) ret_word <= {1'b0, addr, 1'b0, rd_data};
         else                            ret_word <= '0;
      end
   end

   // R3: frame results appear only once chip-select is inactive
   a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !cs_lvl);

   // R4: writes and rejected frames leave nothing to return
   a_r4_ret_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !(frame_ok && op == FRM_READ)) |=> (ret_word == '0));

endmodule

// File: tb/spi_regfile_slave_tb.sv
module spi_regfile_slave_tb;

   localparam int HALF = 6;
   localparam logic [23:0] REV = 24'h0A5C31;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1;
   logic cs = 1'b0;
   logic mosi = 1'b0;
   logic miso;

   always #2 clk = ~clk;

   spi_regfile_slave u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sclk (sclk),
      .spi_cs   (cs),
      .spi_mosi (mosi),
      .spi_miso (miso)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] exp_q [$];
   logic [31:0] got_q [$];
   string       tag_q [$];

   logic [23:0] model [64];
   logic [31:0] ret_model = '0;

   function automatic logic [23:0] model_rd(int a);
      return (a == 7) ? REV : model[a];
   endfunction

   // monitor: compares returned words against the scoreboard
   always @(negedge clk) begin
      while (got_q.size() > 0) begin
         logic [31:0] g, e;
         string t;
         g = got_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (g !== e) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", t, g, e);
         end
      end
   end

   task automatic check_now(input string t, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", t, act, exp);
      end
   endtask

   // driver: one frame of nbits clocks; pushes expected and captured words
   task automatic xfer(input logic [31:0] w, input int nbits, input string t);
      logic [31:0] rx, msk;
      int a;
      rx  = '0;
      msk = (nbits >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> nbits);
      exp_q.push_back(ret_model & msk);
      tag_q.push_back(t);
      @(negedge clk);
      cs = 1'b1;
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 32) ? w[31-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i < 32) rx[31-i] = miso;
         sclk = 1'b0;
         repeat (HALF) @(negedge clk);
         sclk = 1'b1;
      end
      repeat (HALF) @(negedge clk);
      cs = 1'b0;
      got_q.push_back(rx);
      a = int'(w[30:25]);
      if (nbits == 32) begin
         if (w[31]) begin
            if (a != 7) model[a] = w[23:0];
            ret_model = '0;
         end else begin
            ret_model = {1'b0, w[30:25], 1'b0, model_rd(a)};
         end
      end else begin
         ret_model = '0;
      end
      repeat (2*HALF) @(negedge clk);
   endtask

   function automatic logic [31:0] wr_frame(int a, logic [23:0] d, logic spare);
      return {1'b1, 6'(a), spare, d};
   endfunction

   function automatic logic [31:0] rd_frame(int a, logic [23:0] junk);
      return {1'b0, 6'(a), 1'b1, junk};
   endfunction

   function automatic logic [23:0] pattern(int a);
      return 24'(a * 24'h0411F3) ^ 24'hA5A5A5;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 64; a++) model[a] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_now("R1 idle miso", miso, 1'b0);

      // R1: reset contents and first return word
      xfer(rd_frame(5, 24'h00FFEE), 32, "R1 first frame zero");
      xfer(rd_frame(5, 24'h0), 32, "R1 reset value of reg 5");
      check_now("R1 miso low between frames", miso, 1'b0);

      // R2: write with bit 24 set; R4: return after a write is zero
      xfer(wr_frame(5, 24'h123456, 1'b1), 32, "R3 read return before write");
      xfer(rd_frame(5, 24'h0), 32, "R4 zero after write");
      xfer(rd_frame(12, 24'h0), 32, "R2 write data stored bit24 ignored");
      xfer(rd_frame(5, 24'h0), 32, "R2 untouched reg 12 reads zero");

      // R6: revision register
      xfer(wr_frame(7, 24'hFFFFFF, 1'b0), 32, "R3 return of reg 5");
      xfer(rd_frame(7, 24'h0), 32, "R4 zero after write to rev");
      xfer(rd_frame(7, 24'h0), 32, "R6 revision value after write");

      // R5: short and long frames are discarded
      xfer(wr_frame(9, 24'hABCDEF, 1'b0), 20, "R6 rev return partial");
      xfer(rd_frame(9, 24'h0), 32, "R4 zero after short frame");
      xfer(wr_frame(9, 24'h777777, 1'b0), 33, "R5 short write ignored");
      xfer(rd_frame(9, 24'h0), 32, "R4 zero after long frame");
      xfer(rd_frame(9, 24'h0), 32, "R5 long write ignored");
      xfer(rd_frame(3, 24'h0), 20, "R5 reg 9 still zero");
      xfer(rd_frame(9, 24'h0), 32, "R5 short read gives nothing back");

      // R2/R7: fill the whole bank
      for (int a = 0; a < 64; a++)
         xfer(wr_frame(a, pattern(a), a[0]), 32, "R7 write sequence return");

      // R8/R3: pipelined back-to-back reads of every address
      for (int a = 63; a >= 0; a--)
         xfer(rd_frame(a, pattern(a)), 32, "R8 pipelined read data");
      xfer(wr_frame(0, 24'h000001, 1'b0), 32, "R3 last pipelined read");
      xfer(rd_frame(0, 24'h0), 32, "R4 zero after final write");
      xfer(rd_frame(0, 24'h0), 32, "R2 overwrite of reg 0");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule